// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This engine moves received Ethernet frames from a byte-wide AXI4-Stream input into memory buffers that software has set up as a ring of descriptors. Each descriptor takes sixteen bytes: a status word at offset 0 and the buffer start address at offset 12. The other two words are left alone. The engine reads the status word of the current descriptor. If hardware owns it, the engine fetches the buffer address and packs incoming bytes into 32-bit writes with byte enables. At the end of the frame it writes back a status word that hands the descriptor to software and reports the length and the error flags. Then it moves to the next descriptor, and it wraps to the ring base after a descriptor that carries the end-of-ring mark.

If software still owns the current descriptor, the engine raises a no-buffer interrupt status flag and stops. While stopped it accepts and discards whole frames. A write to the poll-demand register makes it try the same descriptor again once any frame in progress has fully passed. Address filtering and CRC checking sit upstream. Their verdicts arrive on the stream's `tuser` sideband.

Software programs the engine through a simple write-only register port with byte offsets: 0x00 interrupt status, 0x1C poll demand, 0x24 ring base, 0x40 buffer size. The memory side is a single-outstanding 32-bit request/acknowledge port.

Top module: `rxd_dma`

## Requirements
- R1: After reset, `irq_nobuf` is low, `mem_req` is low and `s_tready` is high. Frames that arrive before the first poll demand are consumed and never written to memory.
- R2: A write to offset 0x1C (any data), made while the engine is stopped or idle, makes it read the status word at the current descriptor address. Poll-demand writes made at other times are ignored.
- R3: If the status word read has bit 31 set (software-owned), the engine writes nothing to memory, sets `irq_nobuf` and stops until the next poll demand.
- R4: For a hardware-owned descriptor, the engine reads the buffer address from descriptor offset 12. It writes frame byte k to buffer address + k, in little-endian lane order (byte k in lane k mod 4), and only the lanes that carry frame bytes are enabled.
- R5: At the end of a frame the engine writes the status word with bit 31 (ready), bit 29 (first) and bit 28 (last) set, bit 30 copied from the status it read, and bits 13:0 set to the stored byte count. That count includes the 4 trailing CRC bytes.
- R6: The error flags are the OR over all beats of the frame: `tuser[0]` sets status bit 18 (receive error), `tuser[1]` sets bit 19 (CRC error) and `tuser[2]` sets bit 22 (odd nibble count).
- R7: Status bit 21 (runt) is set exactly when the reported length is below MIN_LEN (default 64).
- R8: Bytes beyond the buffer size (offset 0x40, bits 13:0, reset value 1536) are not written. In that case the length reports the buffer size and status bit 20 (too long) is set.
- R9: After the write-back, the next descriptor is at current + 16, or at the ring base if bit 30 was set. A write to offset 0x24 loads both the ring base and the current descriptor pointer.
- R10: Writing offset 0x00 with bit 2 set clears `irq_nobuf`. Writing it with bit 2 clear leaves the flag unchanged.
- R11: Frames that arrive while the engine is stopped are consumed in full and not written. A frame already in progress when a poll demand arrives is still dropped whole, and the next frame goes to the buffer.
- R12: `mem_req`, `mem_addr` and `mem_we` stay stable from the assertion of a request until its `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 8 | Stream byte |
| s_tvalid | input | 1 | Stream byte valid |
| s_tready | output | 1 | Stream byte accepted |
| s_tlast | input | 1 | Last byte of frame |
| s_tuser | input | 3 | Error sideband: [0] receive error, [1] CRC error, [2] odd nibble |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| irq_nobuf | output | 1 | No-buffer interrupt status |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte enables |
| mem_ack | input | 1 | Memory request done; read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
Frames of 70, 20 and 100 bytes go through a three-descriptor ring. The 70-byte frame ends on a partial word, which shows whether the byte enables are right. The 20-byte frame with a CRC flag on its last beat separates the runt and CRC flags. The 100-byte frame uses a 64-byte buffer, a first-beat error flag and the end-of-ring descriptor, which exercises truncation, flag accumulation and wrap-around. The wrap lands on a descriptor that software still owns. Frames sent while the engine is stopped, including one with a poll demand issued mid-frame, must leave the earlier buffer contents intact, and the frame after them must land in the recovered descriptor.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int LEN_W = 14;

    // status word bit positions
    localparam int OWN_BIT   = 31;
    localparam int EOR_BIT   = 30;
    localparam int FIRST_BIT = 29;
    localparam int LAST_BIT  = 28;
    localparam int ODD_BIT   = 22;
    localparam int RUNT_BIT  = 21;
    localparam int LONG_BIT  = 20;
    localparam int CRC_BIT   = 19;
    localparam int RXERR_BIT = 18;

    // register byte offsets
    localparam logic [7:0] OFF_IRQ   = 8'h00;
    localparam logic [7:0] OFF_POLL  = 8'h1C;
    localparam logic [7:0] OFF_BASE  = 8'h24;
    localparam logic [7:0] OFF_BSIZE = 8'h40;
    localparam int         NOBUF_BIT = 2;

    // descriptor geometry
    localparam int DESC_BYTES = 16;
    localparam int BUFPTR_OFF = 12;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_RSTAT,
        ST_RBUF,
        ST_RECV,
        ST_WSTAT
    } eng_state_e;

    typedef struct packed {
        logic             odd_nib;
        logic             runt;
        logic             too_long;
        logic             crc_err;
        logic             rx_err;
        logic [LEN_W-1:0] len;
    } rx_report_t;

    function automatic logic [31:0] pack_status(input logic eor, input rx_report_t r);
        logic [31:0] s;
        s            = '0;
        s[OWN_BIT]   = 1'b1;
        s[EOR_BIT]   = eor;
        s[FIRST_BIT] = 1'b1;
        s[LAST_BIT]  = 1'b1;
        s[ODD_BIT]   = r.odd_nib;
        s[RUNT_BIT]  = r.runt;
        s[LONG_BIT]  = r.too_long;
        s[CRC_BIT]   = r.crc_err;
        s[RXERR_BIT] = r.rx_err;
        s[LEN_W-1:0] = r.len;
        return s;
    endfunction

endpackage

// File: rtl/rxd_regs.sv
module rxd_regs
    import rxd_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DEF_BUF = 1536
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    input  logic             set_nobuf,
    output logic             nobuf,
    output logic [AW-1:0]    ring_base,
    output logic             base_load,
    output logic [LEN_W-1:0] buf_size,
    output logic             poll_hit
);

    logic hit_irq, hit_base, hit_size;

    assign hit_irq  = reg_we && (reg_addr == OFF_IRQ);
    assign hit_base = reg_we && (reg_addr == OFF_BASE);
    assign hit_size = reg_we && (reg_addr == OFF_BSIZE);
    assign poll_hit = reg_we && (reg_addr == OFF_POLL);

    always_ff @(posedge clk) begin
        if (rst) begin
            nobuf     <= 1'b0;
            ring_base <= '0;
            base_load <= 1'b0;
            buf_size  <= LEN_W'(DEF_BUF);
        end else begin
            base_load <= hit_base;
            if (hit_base)
                ring_base <= reg_wdata[AW-1:0];
            if (hit_size)
                buf_size <= reg_wdata[LEN_W-1:0];
            // a new stall event wins over a same-cycle clear
            if (set_nobuf)
                nobuf <= 1'b1;
            else if (hit_irq && reg_wdata[NOBUF_BIT])
                nobuf <= 1'b0;
        end
    end

endmodule

// File: rtl/rxd_packer.sv
module rxd_packer
    import rxd_pkg::*;
#(
    parameter int MIN_LEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             take,
    input  logic             accept,
    input  logic [7:0]       tdata,
    input  logic             tlast,
    input  logic [2:0]       tuser,
    input  logic [LEN_W-1:0] buf_size,
    output logic [31:0]      word,
    output logic [3:0]       be,
    output logic [LEN_W-1:0] word_off,
    output logic             word_rdy,
    output logic             frame_end,
    output rx_report_t       rpt
);

    logic [LEN_W-1:0] kept;
    logic             f_rx, f_crc, f_odd, f_long;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word      <= '0;
            be        <= '0;
            word_off  <= '0;
            word_rdy  <= 1'b0;
            frame_end <= 1'b0;
            kept      <= '0;
            f_rx      <= 1'b0;
            f_crc     <= 1'b0;
            f_odd     <= 1'b0;
            f_long    <= 1'b0;
        end else if (take) begin
            word     <= '0;
            be       <= '0;
            word_rdy <= 1'b0;
        end else if (accept) begin
            if (kept < buf_size) begin
                word[{kept[1:0], 3'b000} +: 8] <= tdata;
                be[kept[1:0]]                  <= 1'b1;
                word_off                       <= {kept[LEN_W-1:2], 2'b00};
                kept                           <= kept + LEN_W'(1);
                if (kept[1:0] == 2'd3)
                    word_rdy <= 1'b1;
            end else begin
                f_long <= 1'b1;
            end
            if (tlast) begin
                word_rdy  <= 1'b1;
                frame_end <= 1'b1;
            end
            f_rx  <= f_rx  | tuser[0];
            f_crc <= f_crc | tuser[1];
            f_odd <= f_odd | tuser[2];
        end
    end

    always_comb begin
        rpt.len      = kept;
        rpt.runt     = kept < LEN_W'(MIN_LEN);
        rpt.too_long = f_long;
        rpt.rx_err   = f_rx;
        rpt.crc_err  = f_crc;
        rpt.odd_nib  = f_odd;
    end

endmodule

// File: rtl/rxd_fsm.sv
module rxd_fsm
    import rxd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    ring_base,
    input  logic             base_load,
    input  logic             poll_hit,
    input  logic             s_tvalid,
    input  logic             s_tlast,
    output logic             s_tready,
    input  logic [31:0]      word,
    input  logic [3:0]       be,
    input  logic [LEN_W-1:0] word_off,
    input  logic             word_rdy,
    input  logic             frame_end,
    input  rx_report_t       rpt,
    output logic             pk_clear,
    output logic             pk_take,
    output logic             set_nobuf,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    output logic [3:0]       mem_be,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic [AW-1:0]    desc_addr
);

    eng_state_e    state;
    logic [AW-1:0] desc_ptr, buf_ptr;
    logic          eor, pend, mid, go;

    assign desc_addr = desc_ptr;
    assign go        = (state == ST_WAIT) && pend && !mid;

    always_comb begin
        s_tready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_ptr;
        mem_wdata = '0;
        mem_be    = 4'hF;
        pk_take   = 1'b0;
        unique case (state)
            ST_WAIT:  s_tready = !go;
            ST_RSTAT: mem_req = 1'b1;
            ST_RBUF: begin
                mem_req  = 1'b1;
                mem_addr = desc_ptr + AW'(BUFPTR_OFF);
            end
            ST_RECV: begin
                s_tready = !word_rdy;
                if (word_rdy && (be != 4'h0)) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = buf_ptr + AW'(word_off);
                    mem_wdata = word;
                    mem_be    = be;
                end
                pk_take = word_rdy && ((be == 4'h0) || mem_ack);
            end
            ST_WSTAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = pack_status(eor, rpt);
            end
            default: ;
        endcase
    end

    assign set_nobuf = (state == ST_RSTAT) && mem_ack && mem_rdata[OWN_BIT];
    assign pk_clear  = (state == ST_RBUF) && mem_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_WAIT;
            desc_ptr <= '0;
            buf_ptr  <= '0;
            eor      <= 1'b0;
            pend     <= 1'b0;
            mid      <= 1'b0;
        end else begin
            unique case (state)
                ST_WAIT: begin
                    if (poll_hit)
                        pend <= 1'b1;
                    if (s_tvalid && s_tready)
                        mid <= !s_tlast;
                    if (go) begin
                        pend  <= 1'b0;
                        state <= ST_RSTAT;
                    end
                end
                ST_RSTAT: if (mem_ack) begin
                    if (mem_rdata[OWN_BIT]) begin
                        state <= ST_WAIT;
                    end else begin
                        eor   <= mem_rdata[EOR_BIT];
                        state <= ST_RBUF;
                    end
                end
                ST_RBUF: if (mem_ack) begin
                    buf_ptr <= mem_rdata[AW-1:0];
                    state   <= ST_RECV;
                end
                ST_RECV: if (pk_take && frame_end)
                    state <= ST_WSTAT;
                ST_WSTAT: if (mem_ack) begin
                    desc_ptr <= eor ? ring_base : desc_ptr + AW'(DESC_BYTES);
                    state    <= ST_RSTAT;
                end
                default: state <= ST_WAIT;
            endcase
            if (base_load)
                desc_ptr <= ring_base;
        end
    end

endmodule

// File: rtl/rxd_dma.sv
module rxd_dma
    import rxd_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DEF_BUF = 1536,
    parameter int MIN_LEN = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    s_tdata,
    input  logic          s_tvalid,
    output logic          s_tready,
    input  logic          s_tlast,
    input  logic [2:0]    s_tuser,
    input  logic          reg_we,
    input  logic [7:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic          irq_nobuf,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [3:0]    mem_be,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata
);

    logic [AW-1:0]    ring_base, cur_desc;
    logic             base_load, poll_hit, set_nobuf;
    logic [LEN_W-1:0] buf_size, word_off;
    logic [31:0]      word;
    logic [3:0]       be;
    logic             word_rdy, frame_end, pk_clear, pk_take, accept;
    rx_report_t       rpt;

    assign accept = s_tvalid && s_tready;

    rxd_regs #(.AW(AW), .DEF_BUF(DEF_BUF)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .set_nobuf(set_nobuf), .nobuf(irq_nobuf),
        .ring_base(ring_base), .base_load(base_load),
        .buf_size(buf_size), .poll_hit(poll_hit)
    );

    rxd_packer #(.MIN_LEN(MIN_LEN)) u_pack (
        .clk(clk), .rst(rst), .clear(pk_clear), .take(pk_take),
        .accept(accept), .tdata(s_tdata), .tlast(s_tlast), .tuser(s_tuser),
        .buf_size(buf_size), .word(word), .be(be), .word_off(word_off),
        .word_rdy(word_rdy), .frame_end(frame_end), .rpt(rpt)
    );

    rxd_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst(rst),
        .ring_base(ring_base), .base_load(base_load), .poll_hit(poll_hit),
        .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
        .word(word), .be(be), .word_off(word_off), .word_rdy(word_rdy),
        .frame_end(frame_end), .rpt(rpt),
        .pk_clear(pk_clear), .pk_take(pk_take), .set_nobuf(set_nobuf),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .desc_addr(cur_desc)
    );

endmodule

// File: rtl/rxd_dma_chk.sv
module rxd_dma_chk
    import rxd_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MIN_LEN = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             s_tready,
    input logic             reg_we,
    input logic [7:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             irq_nobuf,
    input logic             mem_req,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             mem_ack,
    input logic [31:0]      mem_rdata,
    input logic [AW-1:0]    cur_desc,
    input logic [LEN_W-1:0] buf_size,
    input logic             set_nobuf
);

    logic stat_wr;
    assign stat_wr = mem_req && mem_we && (mem_addr == cur_desc);

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    assert_no_stream_in_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we |-> !s_tready);

    assert_status_flags_R5: assert property (@(posedge clk) disable iff (rst)
        stat_wr |-> mem_wdata[OWN_BIT] && mem_wdata[FIRST_BIT] && mem_wdata[LAST_BIT]);

    assert_len_bound_R8: assert property (@(posedge clk) disable iff (rst)
        stat_wr |-> mem_wdata[LEN_W-1:0] <= buf_size);

    assert_runt_flag_R7: assert property (@(posedge clk) disable iff (rst)
        stat_wr |-> mem_wdata[RUNT_BIT] == (mem_wdata[LEN_W-1:0] < LEN_W'(MIN_LEN)));

    assert_irq_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_nobuf) |-> $past(mem_ack && !mem_we && mem_rdata[OWN_BIT]
                                   && (mem_addr == cur_desc)));

    assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
        reg_we && (reg_addr == OFF_IRQ) && reg_wdata[NOBUF_BIT] && !set_nobuf |=> !irq_nobuf);

endmodule

bind rxd_dma rxd_dma_chk #(.AW(AW), .MIN_LEN(MIN_LEN)) u_chk (
    .clk(clk), .rst(rst), .s_tready(s_tready),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .irq_nobuf(irq_nobuf), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .cur_desc(cur_desc), .buf_size(buf_size),
    .set_nobuf(set_nobuf)
);

// File: tb/sim_rxd_dma.sv
`timescale 1ns/1ps
module sim_rxd_dma;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  s_tdata = '0;
    logic        s_tvalid = 1'b0, s_tlast = 1'b0;
    logic [2:0]  s_tuser = '0;
    logic        s_tready;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        irq_nobuf;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;

    logic        tb_we = 1'b0;
    logic [31:0] tb_addr = '0, tb_data = '0;
    logic [31:0] mem [0:1023];
    logic        hs_wait;
    logic [31:0] hs_addr;
    int          hs_viol;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rxd_dma u0 (
        .clk(clk), .rst(rst),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tlast(s_tlast), .s_tuser(s_tuser),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .irq_nobuf(irq_nobuf),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory model: acknowledges one cycle after a request
    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            hs_wait   <= 1'b0;
            hs_addr   <= '0;
            hs_viol   <= 0;
            for (int i = 0; i < 1024; i++) mem[i] <= 32'hEEEE_EEEE;
        end else begin
            mem_ack   <= mem_req && !mem_ack;
            mem_rdata <= mem[mem_addr[11:2]];
            if (mem_req && !mem_ack && mem_we)
                for (int l = 0; l < 4; l++)
                    if (mem_be[l]) mem[mem_addr[11:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
            if (tb_we) mem[tb_addr[11:2]] <= tb_data;
            if (hs_wait && (!mem_req || mem_addr != hs_addr)) hs_viol <= hs_viol + 1;
            hs_wait <= mem_req && !mem_ack;
            hs_addr <= mem_addr;
        end
    end

    function automatic logic [7:0] byte_at(input logic [31:0] a);
        return mem[a[11:2]][8*a[1:0] +: 8];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); tb_we = 1'b1; tb_addr = a; tb_data = d;
        @(negedge clk); tb_we = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic send_frame(input int n, input logic [7:0] seed,
                              input logic [2:0] u_first, input logic [2:0] u_last,
                              input int poll_at);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_tvalid = 1'b1;
            s_tdata  = seed + 8'(i);
            s_tlast  = (i == n - 1);
            s_tuser  = (i == 0 ? u_first : 3'b000) | (i == n - 1 ? u_last : 3'b000);
            reg_we   = (i == poll_at);
            reg_addr = 8'h1C;
            reg_wdata = 32'h1;
            #3;
            while (!s_tready) begin
                @(negedge clk);
                reg_we = 1'b0;
                #3;
            end
        end
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0; s_tuser = '0; reg_we = 1'b0;
    endtask

    // R1: reset state and frames before the first poll are discarded
    task automatic t_reset;
        wait_cyc(2);
        chk("R1 irq after reset", 32'(irq_nobuf), 32'd0);
        chk("R1 mem_req after reset", 32'(mem_req), 32'd0);
        chk("R1 tready after reset", 32'(s_tready), 32'd1);
        poke(32'h100, 32'h0);          poke(32'h10C, 32'h400);
        poke(32'h110, 32'h0);          poke(32'h11C, 32'h600);
        poke(32'h120, 32'h4000_0000);  poke(32'h12C, 32'h800);
        reg_wr(8'h24, 32'h100);
        send_frame(5, 8'h01, 3'b000, 3'b000, -1);
        wait_cyc(20);
        chk("R1 pre-poll frame not stored", 32'(byte_at(32'h400)), 32'hEE);
        chk("R1 no irq before poll", 32'(irq_nobuf), 32'd0);
    endtask

    // R2 R4 R5: plain frame with partial last word
    task automatic t_plain;
        reg_wr(8'h1C, 32'h1);
        send_frame(70, 8'h10, 3'b000, 3'b000, -1);
        wait_cyc(30);
        chk("R4 byte 0", 32'(byte_at(32'h400)), 32'h10);
        chk("R4 byte 69", 32'(byte_at(32'h445)), 32'h55);
        chk("R4 byte 70 untouched", 32'(byte_at(32'h446)), 32'hEE);
        chk("R5 status d0", mem[32'h100 >> 2], 32'hB000_0046);
    endtask

    // R6 R7: short frame with CRC error flag
    task automatic t_runt;
        send_frame(20, 8'h80, 3'b000, 3'b010, -1);
        wait_cyc(30);
        chk("R4 d1 byte 19", 32'(byte_at(32'h613)), 32'h93);
        chk("R6 R7 status d1", mem[32'h110 >> 2], 32'hB028_0014);
    endtask

    // R8 R6 R9: truncation, flag accumulation, end-of-ring, wrap onto owned desc (R3)
    task automatic t_trunc;
        reg_wr(8'h40, 32'd64);
        send_frame(100, 8'hA0, 3'b101, 3'b000, -1);
        wait_cyc(30);
        chk("R8 byte 63 stored", 32'(byte_at(32'h83F)), 32'hDF);
        chk("R8 byte 64 not stored", 32'(byte_at(32'h840)), 32'hEE);
        chk("R8 R6 status d2", mem[32'h120 >> 2], 32'hF054_0040);
        chk("R3 R9 irq on wrapped owned desc", 32'(irq_nobuf), 32'd1);
        chk("R3 d0 status untouched", mem[32'h100 >> 2], 32'hB000_0046);
    endtask

    // R11 R10: drop while stalled, interrupt clear semantics
    task automatic t_stall;
        send_frame(10, 8'h70, 3'b000, 3'b000, -1);
        wait_cyc(20);
        chk("R11 stalled frame not stored", 32'(byte_at(32'h400)), 32'h10);
        chk("R11 d0 status kept", mem[32'h100 >> 2], 32'hB000_0046);
        reg_wr(8'h00, 32'h0);
        wait_cyc(2);
        chk("R10 write 0 keeps irq", 32'(irq_nobuf), 32'd1);
        reg_wr(8'h00, 32'h4);
        wait_cyc(2);
        chk("R10 write 1 clears irq", 32'(irq_nobuf), 32'd0);
    endtask

    // R11 R2 R9: poll mid-frame, that frame dropped, next lands in recovered d0
    task automatic t_recover;
        poke(32'h100, 32'h0);
        send_frame(12, 8'h55, 3'b000, 3'b000, 3);
        send_frame(8, 8'h30, 3'b000, 3'b000, -1);
        wait_cyc(30);
        chk("R9 R11 new frame byte 0 at d0", 32'(byte_at(32'h400)), 32'h30);
        chk("R11 in-progress frame dropped", 32'(byte_at(32'h40A)), 32'h1A);
        chk("R2 R7 status d0 after retry", mem[32'h100 >> 2], 32'hB020_0008);
        chk("R3 stall on owned d1", 32'(irq_nobuf), 32'd1);
        reg_wr(8'h00, 32'h4);
        wait_cyc(2);
        chk("R10 cleared again", 32'(irq_nobuf), 32'd0);
        reg_wr(8'h1C, 32'h1);
        wait_cyc(10);
        chk("R2 R3 retry of owned desc sets irq", 32'(irq_nobuf), 32'd1);
        chk("R12 memory handshake stable", 32'(hs_viol), 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_plain;
        t_runt;
        t_trunc;
        t_stall;
        t_recover;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule